// File: doc/BRIEF.md
# Sliced Text Line Buffer and Burst Framer

This block sits between a vertical-blanking text slicer and a shared byte-wide output bus. Sliced bytes are written into one of two line sections. When the slicer strobes the end of a line, that section is sealed along with its line number and standard code, and filling moves to the other section. A sealed section raises a transfer request. Once the request is granted, the line leaves the block as a single unbroken qualified burst. A six-byte header leads the burst, and the line's payload bytes follow it.

The header takes one of two forms, and a 6-bit data identifier chooses between them. Identifiers below 0x3E give an ancillary-data preamble. The values 0x3E and 0x3F give a timing-reference style code with a status byte. A framing flag rises together with the first header byte. It stays up until the video path reports a start-of-active-video code, so the flag can cover several text lines in a row. An optional recoding step keeps the reserved values 0x00 and 0xFF out of the payload.

Top module: `vbi_line_framer`

## Requirements
- R1: Bytes presented with `in_valid` are stored in order into the filling section. A pulse on `in_line_end` seals the line and captures `line_num` and `std_code`. A byte presented in the same cycle as `in_line_end` is the last byte of that line.
- R2: `out_req` is low after reset. It is high only while the block is idle and at least one sealed line is waiting. It drops in the cycle after a grant is accepted.
- R3: After `out_grant` is accepted, `out_dq` stays high for exactly 6 + N consecutive cycles, where N is the line length. The 6 header bytes come first and the N payload bytes follow, with no idle cycle between any of them.
- R4: When `cfg_did` < 0x3E, the header is 0x00, 0xFF, 0xFF, {2'b00, cfg_did}, line number, standard code.
- R5: When `cfg_did` is 0x3E or 0x3F, the header is 0xFF, 0x00, 0x00, S, line number, standard code. S is 0xB6 for 0x3E and 0xF1 for 0x3F.
- R6: `out_flag` is low after reset. It rises in the cycle the first header byte is on `out_byte` and stays high across later bursts. It falls one cycle after `vid_sav` is sampled high while no text byte is in flight. A `vid_sav` pulse during a burst is ignored.
- R7: Whenever `out_dq` is high, `out_flag` is high.
- R8: Whenever `out_dq` is low, `out_byte` is 0x00.
- R9: With `cfg_recode` = 1, payload byte 0x00 is sent as 0x03 and 0xFF is sent as 0xFC. With `cfg_recode` = 0, payload bytes pass unchanged. Header bytes are never recoded.
- R10: If `in_line_end` arrives while both sections hold sealed lines, the new line is discarded and `overflow` is set. `overflow` stays set until reset. The held lines are still sent intact.
- R11: Each section holds at most DEPTH (default 64) bytes. Bytes beyond DEPTH in a line are dropped, and the line is sent with length DEPTH.
- R12: Sealed lines are sent in the order they were sealed. A line of length 0 is sent as a header only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slicer byte strobe |
| in_byte | input | 8 | Sliced byte |
| in_line_end | input | 1 | End-of-line strobe from the slicer |
| line_num | input | 8 | Line number, captured at line end |
| std_code | input | 8 | Video standard code, captured at line end |
| cfg_did | input | 6 | Data identifier selecting header form |
| cfg_recode | input | 1 | Enables recoding of reserved payload values |
| out_grant | input | 1 | Permission to start the requested burst |
| vid_sav | input | 1 | Start-of-active-video code is on the shared bus |
| out_req | output | 1 | A sealed line is waiting for transfer |
| out_byte | output | 8 | Output byte |
| out_dq | output | 1 | Output byte qualifier |
| out_flag | output | 1 | Sliced-data framing flag |
| overflow | output | 1 | Sticky lost-line indicator |

## Verification
Lines are written with incrementing runs that cross 0xFF into 0x00, with alternating 0x00/0xFF payloads, and with XOR-scrambled payloads. Each is framed under ancillary identifiers and under both timing-code identifiers, with recoding on and off, so that the header form, the status byte and the recode path can be told apart. Edge lengths of 0, 1 and 64 bytes, and an over-long line, separate the length handling from the sealing. A byte merged with the line-end strobe checks the off-by-one case at the seal. Two queued lines followed by a third show the overflow drop and the order of service. A clear pulse sent mid-burst and one sent after the bursts tell the flag's guard apart from its clear.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_HDR  = 2'd1,
    RD_DATA = 2'd2
  } rd_state_t;

  localparam int HDR_LEN = 6;

  // Keep the two reserved values out of the payload when enabled.
  function automatic logic [7:0] recode_byte(input logic [7:0] b, input logic en);
    if (en && b == 8'h00)      return 8'h03;
    else if (en && b == 8'hFF) return 8'hFC;
    else                       return b;
  endfunction

  // Timing-reference status byte: V=1, H=1, F from the identifier LSB,
  // protection bits computed from F, V and H.
  function automatic logic [7:0] trs_status(input logic f);
    logic v, h;
    v = 1'b1;
    h = 1'b1;
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vbi_pingpong_mem.sv
module vbi_pingpong_mem #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW:0]   raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 ** (AW + 1);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vbi_write_side.sv
module vbi_write_side #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  input  logic                 in_line_end,
  input  logic [7:0]           line_num,
  input  logic [7:0]           std_code,
  input  logic                 rel,
  input  logic                 rel_sel,
  output logic [1:0]           full,
  output logic [1:0][CW-1:0]   sec_len,
  output logic [1:0][7:0]      sec_ln,
  output logic [1:0][7:0]      sec_std,
  output logic                 mem_we,
  output logic [AW:0]          mem_waddr,
  output logic [7:0]           mem_wdata,
  output logic                 overflow
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          wsel;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] cnt_next;
  logic          wr_ok;
  logic [1:0]    full_d;

  assign wr_ok     = in_valid && !full[wsel] && (wcnt < DEPTH_C);
  assign cnt_next  = wcnt + CW'(wr_ok);
  assign mem_we    = wr_ok;
  assign mem_waddr = {wsel, wcnt[AW-1:0]};
  assign mem_wdata = in_byte;

  always_comb begin
    full_d = full;
    if (rel) full_d[rel_sel] = 1'b0;
    if (in_line_end && !full[wsel]) full_d[wsel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel     <= 1'b0;
      wcnt     <= '0;
      full     <= '0;
      overflow <= 1'b0;
      sec_len  <= '0;
      sec_ln   <= '0;
      sec_std  <= '0;
    end else begin
      full <= full_d;
      if (in_line_end) begin
        wcnt <= '0;
        if (full[wsel]) begin
          overflow <= 1'b1;
        end else begin
          sec_len[wsel] <= cnt_next;
          sec_ln[wsel]  <= line_num;
          sec_std[wsel] <= std_code;
          wsel          <= ~wsel;
        end
      end else begin
        wcnt <= cnt_next;
      end
    end
  end
endmodule

// File: rtl/vbi_header_gen.sv
module vbi_header_gen
  import vbi_pkg::*;
(
  input  logic [2:0] idx,
  input  logic [5:0] did,
  input  logic [7:0] ln,
  input  logic [7:0] st,
  output logic [7:0] hdr_byte
);
  logic trs_form;

  assign trs_form = (did >= 6'h3E);

  always_comb begin
    unique case (idx)
      3'd0:    hdr_byte = trs_form ? 8'hFF : 8'h00;
      3'd1:    hdr_byte = trs_form ? 8'h00 : 8'hFF;
      3'd2:    hdr_byte = trs_form ? 8'h00 : 8'hFF;
      3'd3:    hdr_byte = trs_form ? trs_status(did[0]) : {2'b00, did};
      3'd4:    hdr_byte = ln;
      3'd5:    hdr_byte = st;
      default: hdr_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/vbi_line_framer.sv
module vbi_line_framer
  import vbi_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_line_end,
  input  logic [7:0] line_num,
  input  logic [7:0] std_code,
  input  logic [5:0] cfg_did,
  input  logic       cfg_recode,
  input  logic       out_grant,
  input  logic       vid_sav,
  output logic       out_req,
  output logic [7:0] out_byte,
  output logic       out_dq,
  output logic       out_flag,
  output logic       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR_LEN - 1);

  logic [1:0]          full;
  logic [1:0][CW-1:0]  sec_len;
  logic [1:0][7:0]     sec_ln;
  logic [1:0][7:0]     sec_std;
  logic                mem_we;
  logic [AW:0]         mem_waddr;
  logic [7:0]          mem_wdata;
  logic [7:0]          mem_rdata;

  rd_state_t     state;
  logic          rsel;
  logic [CW-1:0] idx;
  logic [CW-1:0] cur_len;
  logic          rel;
  logic [7:0]    hdr_byte;

  logic          p1_valid, p1_data, p1_first;
  logic [7:0]    p1_hdr;

  vbi_write_side #(.DEPTH(DEPTH)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_line_end(in_line_end),
    .line_num   (line_num),
    .std_code   (std_code),
    .rel        (rel),
    .rel_sel    (rsel),
    .full       (full),
    .sec_len    (sec_len),
    .sec_ln     (sec_ln),
    .sec_std    (sec_std),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .overflow   (overflow)
  );

  vbi_pingpong_mem #(.DW(8), .AW(AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr({rsel, idx[AW-1:0]}),
    .rdata(mem_rdata)
  );

  vbi_header_gen u_hdr (
    .idx     (idx[2:0]),
    .did     (cfg_did),
    .ln      (sec_ln[rsel]),
    .st      (sec_std[rsel]),
    .hdr_byte(hdr_byte)
  );

  assign cur_len = sec_len[rsel];
  assign out_req = (state == RD_IDLE) && full[rsel];

  // Section is handed back once its last byte address has been issued.
  assign rel = ((state == RD_DATA) && (idx == cur_len - 1'b1)) ||
               ((state == RD_HDR) && (idx == HDR_LAST) && (cur_len == '0));

  // Read sequencer: header then payload, one byte per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RD_IDLE;
      rsel  <= 1'b0;
      idx   <= '0;
    end else begin
      unique case (state)
        RD_IDLE: begin
          idx <= '0;
          if (out_grant && full[rsel]) state <= RD_HDR;
        end
        RD_HDR: begin
          if (idx == HDR_LAST) begin
            idx <= '0;
            if (cur_len == '0) begin
              state <= RD_IDLE;
              rsel  <= ~rsel;
            end else begin
              state <= RD_DATA;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        RD_DATA: begin
          if (idx == cur_len - 1'b1) begin
            idx   <= '0;
            state <= RD_IDLE;
            rsel  <= ~rsel;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  // Stage 1: aligns with the synchronous memory read.
  always_ff @(posedge clk) begin
    if (rst) begin
      p1_valid <= 1'b0;
      p1_data  <= 1'b0;
      p1_first <= 1'b0;
      p1_hdr   <= '0;
    end else begin
      p1_valid <= (state != RD_IDLE);
      p1_data  <= (state == RD_DATA);
      p1_first <= (state == RD_HDR) && (idx == '0);
      p1_hdr   <= hdr_byte;
    end
  end

  // Stage 2: registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_dq   <= 1'b0;
      out_byte <= 8'h00;
      out_flag <= 1'b0;
    end else begin
      out_dq <= p1_valid;
      if (!p1_valid)    out_byte <= 8'h00;
      else if (p1_data) out_byte <= recode_byte(mem_rdata, cfg_recode);
      else              out_byte <= p1_hdr;
      if (p1_first)                  out_flag <= 1'b1;
      else if (vid_sav && !p1_valid) out_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/vbi_line_framer_chk.sv
module vbi_line_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       out_req,
  input logic       out_grant,
  input logic       out_dq,
  input logic       out_flag,
  input logic [7:0] out_byte,
  input logic       vid_sav,
  input logic       overflow
);
  assert_req_drops_after_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (out_req && out_grant) |=> !out_req);

  assert_flag_rises_with_data_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_flag) |-> out_dq);

  assert_flag_falls_on_sav_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(out_flag) |-> $past(vid_sav));

  assert_dq_inside_flag_R7: assert property (@(posedge clk) disable iff (rst)
    out_dq |-> out_flag);

  assert_idle_byte_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !out_dq |-> (out_byte == 8'h00));

  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind vbi_line_framer vbi_line_framer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .out_req  (out_req),
  .out_grant(out_grant),
  .out_dq   (out_dq),
  .out_flag (out_flag),
  .out_byte (out_byte),
  .vid_sav  (vid_sav),
  .overflow (overflow)
);

// File: tb/test_vbi_line_framer.sv
module test_vbi_line_framer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] ln;
    logic [7:0] st;
    logic [5:0] did;
    logic       rec;
    logic [1:0] kind;
    logic [7:0] base;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd8,  8'd10, 8'd1, 6'h15, 1'b0, 2'd0, 8'h40},
    '{8'd8,  8'd11, 8'd1, 6'h15, 1'b1, 2'd1, 8'h00},
    '{8'd8,  8'd12, 8'd2, 6'h15, 1'b0, 2'd1, 8'h00},
    '{8'd6,  8'd13, 8'd2, 6'h3E, 1'b1, 2'd0, 8'hFD},
    '{8'd5,  8'd14, 8'd3, 6'h3F, 1'b0, 2'd0, 8'hFE},
    '{8'd64, 8'd21, 8'd4, 6'h3D, 1'b1, 2'd2, 8'h5A},
    '{8'd1,  8'd22, 8'd0, 6'h00, 1'b0, 2'd0, 8'h77},
    '{8'd0,  8'd23, 8'd5, 6'h3F, 1'b1, 2'd0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_line_end = 1'b0;
  logic [7:0] line_num = 8'h00;
  logic [7:0] std_code = 8'h00;
  logic [5:0] cfg_did = 6'h00;
  logic       cfg_recode = 1'b0;
  logic       out_grant = 1'b0;
  logic       vid_sav = 1'b0;
  logic       out_req;
  logic [7:0] out_byte;
  logic       out_dq;
  logic       out_flag;
  logic       overflow;

  int n_vec = 0;
  int n_bad = 0;

  vbi_line_framer i_vbi_line_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_line_end(in_line_end), .line_num(line_num), .std_code(std_code),
    .cfg_did(cfg_did), .cfg_recode(cfg_recode), .out_grant(out_grant),
    .vid_sav(vid_sav), .out_req(out_req), .out_byte(out_byte),
    .out_dq(out_dq), .out_flag(out_flag), .overflow(overflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [1:0] kind, input logic [7:0] base, input int k);
    logic [7:0] kb;
    kb = 8'(k);
    case (kind)
      2'd0:    return base + kb;
      2'd1:    return kb[0] ? 8'hFF : 8'h00;
      default: return base ^ (kb * 8'h1D);
    endcase
  endfunction

  function automatic logic [7:0] exp_hdr(input logic [5:0] did, input logic [7:0] ln,
                                         input logic [7:0] st, input int k);
    logic t;
    t = (did == 6'h3E) || (did == 6'h3F);
    case (k)
      0: return t ? 8'hFF : 8'h00;
      1: return t ? 8'h00 : 8'hFF;
      2: return t ? 8'h00 : 8'hFF;
      3: return t ? ((did == 6'h3E) ? 8'hB6 : 8'hF1) : {2'b00, did};
      4: return ln;
      default: return st;
    endcase
  endfunction

  function automatic logic [7:0] exp_pay(input logic rec, input logic [7:0] b);
    if (rec && b == 8'h00) return 8'h03;
    if (rec && b == 8'hFF) return 8'hFC;
    return b;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_line(input int len, input logic [7:0] ln, input logic [7:0] st,
                            input logic [1:0] kind, input logic [7:0] base, input logic merge);
    line_num = ln;
    std_code = st;
    for (int k = 0; k < len; k++) begin
      in_valid    = 1'b1;
      in_byte     = pat(kind, base, k);
      in_line_end = merge && (k == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (!(merge && len > 0)) begin
      in_line_end = 1'b1;
      @(negedge clk);
    end
    in_line_end = 1'b0;
  endtask

  task automatic run_burst(input logic [7:0] ln, input logic [7:0] st, input int len,
                           input logic [1:0] kind, input logic [7:0] base, input logic sav_mid);
    int w;
    chk(out_req == 1'b1, "R2 request before grant", 32'(out_req), 1);
    out_grant = 1'b1;
    @(negedge clk);
    out_grant = 1'b0;
    w = 0;
    while (!out_dq && w < 10) begin
      @(negedge clk);
      w++;
    end
    chk(out_dq == 1'b1, "R3 burst start", 32'(out_dq), 1);
    for (int k = 0; k < 6; k++) begin
      vid_sav = 1'b0;
      chk(out_dq == 1'b1, "R3 header qualifier", 32'(out_dq), 1);
      chk(out_byte == exp_hdr(cfg_did, ln, st, k), "R4/R5 header byte",
          32'(out_byte), 32'(exp_hdr(cfg_did, ln, st, k)));
      chk(out_flag == 1'b1, "R6/R7 flag during header", 32'(out_flag), 1);
      if (sav_mid && k == 2) vid_sav = 1'b1;
      @(negedge clk);
    end
    vid_sav = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk(out_dq == 1'b1, "R3 payload qualifier", 32'(out_dq), 1);
      chk(out_byte == exp_pay(cfg_recode, pat(kind, base, k)), "R9/R12 payload byte",
          32'(out_byte), 32'(exp_pay(cfg_recode, pat(kind, base, k))));
      @(negedge clk);
    end
    chk(out_dq == 1'b0, "R3 burst length", 32'(out_dq), 0);
    chk(out_byte == 8'h00, "R8 idle byte", 32'(out_byte), 0);
    chk(out_flag == 1'b1, "R6 flag held after burst", 32'(out_flag), 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // Reset state: R2, R6, R8, R10
    chk(out_req == 1'b0,   "R2 reset req",      32'(out_req), 0);
    chk(out_dq == 1'b0,    "R8 reset dq",       32'(out_dq), 0);
    chk(out_byte == 8'h00, "R8 reset byte",     32'(out_byte), 0);
    chk(out_flag == 1'b0,  "R6 reset flag",     32'(out_flag), 0);
    chk(overflow == 1'b0,  "R10 reset overflow", 32'(overflow), 0);

    // Vector table: R1, R3, R4, R5, R9, R12; i==2 merges last byte with strobe (R1),
    // i==4 sends a clear pulse mid-burst (R6), i==7 is a header-only line (R12).
    for (int i = 0; i < 8; i++) begin
      write_line(int'(VECS[i].len), VECS[i].ln, VECS[i].st, VECS[i].kind, VECS[i].base, i == 2);
      cfg_did    = VECS[i].did;
      cfg_recode = VECS[i].rec;
      run_burst(VECS[i].ln, VECS[i].st, int'(VECS[i].len), VECS[i].kind, VECS[i].base, i == 4);
    end

    // R6: flag spans lines until clear pulse
    chk(out_flag == 1'b1, "R6 flag spans lines", 32'(out_flag), 1);
    vid_sav = 1'b1;
    @(negedge clk);
    vid_sav = 1'b0;
    chk(out_flag == 1'b0, "R6 flag cleared by sav", 32'(out_flag), 0);

    // R11: over-long line truncated to 64
    cfg_did = 6'h20;
    cfg_recode = 1'b0;
    write_line(70, 8'd40, 8'd6, 2'd0, 8'h00, 1'b0);
    run_burst(8'd40, 8'd6, 64, 2'd0, 8'h00, 1'b0);

    // R10, R12: two held lines, third dropped
    write_line(4, 8'd30, 8'd1, 2'd0, 8'h10, 1'b0);
    write_line(3, 8'd31, 8'd1, 2'd0, 8'h20, 1'b0);
    chk(overflow == 1'b0, "R10 no overflow with one free", 32'(overflow), 0);
    write_line(5, 8'd32, 8'd1, 2'd0, 8'h30, 1'b0);
    chk(overflow == 1'b1, "R10 overflow set", 32'(overflow), 1);
    run_burst(8'd30, 8'd1, 4, 2'd0, 8'h10, 1'b0);
    run_burst(8'd31, 8'd1, 3, 2'd0, 8'h20, 1'b0);
    chk(out_req == 1'b0, "R10 dropped line not requested", 32'(out_req), 0);
    chk(overflow == 1'b1, "R10 overflow sticky", 32'(overflow), 1);

    do_reset();
    chk(overflow == 1'b0, "R10 overflow cleared by reset", 32'(overflow), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule